// File: doc/BRIEF.md
# Masked Trap Capture Unit

This unit sits between a set of trap request lines and a processor's trap entry logic. Each request line belongs to one of four trap classes: asynchronous, overflow, data-type or synchronous. A request counts only when the enable for its class and a master trap gate are both set. When any request counts and no trap is already in progress, the unit sends the processor a one-cycle entry pulse and records the request lines in a read-only trap register. It then waits for the processor to signal that the trap has ended.

The master gate lives in a software-writable control register. Hardware clears the gate when a trap is entered and sets it again when the trap exits, so a handler runs with trapping closed unless software opens it. The control register also holds a single-step option. When that option is set at trap exit, a trace trap is raised once the first instruction after the exit has retired. Each write to the control register also reloads the trap register, so software can take a snapshot of the current request lines without taking a trap. Vector dispatch, saving the program counter and the sources of the requests are outside this unit.

All ports are plain control and status signals. There is no streaming data path and no back-pressure: a control write is accepted in the cycle its strobe is high, and the entry pulse is a single-cycle event that the processor must not miss.

Top module: `trap_capture_unit`

## Requirements
- R1: After reset the control register reads 0, the trap register reads 0, `trap_active` is 0 and `trap_entry` is 0.
- R2: Control bits 31:26 are stored when `ctl_wr_en` is high. Control bits 25:0 always read as 0. Bit 31 is the master gate. Bits 30, 29, 28 and 27 enable the asynchronous, overflow, data-type and synchronous classes. Bit 26 enables single-step.
- R3: Request bits 10:1 are asynchronous, bit 12 is overflow, bit 13 is data-type, and bits 31 and 29:15 are synchronous. A request is effective only when control bit 31 and its class enable are both 1. Request inputs 30, 14, 11 and 0 never cause a trap.
- R4: If an effective request is present at a clock edge while no trap is active, `trap_entry` is high for exactly the following cycle and `trap_active` becomes 1 at the same edge.
- R5: While `trap_active` is 1, no further entry pulse is issued. This holds even when software reopens the gate and requests are still held.
- R6: The edge that starts a trap clears control bit 31. This clear wins over a control write in the same cycle, while the other written bits are still stored.
- R7: `trap_exit` while a trap is active clears `trap_active` and sets control bit 31 at the next edge. `trap_exit` while no trap is active has no effect.
- R8: On trap entry the trap register loads the request inputs, with bits 30, 14, 11 and 0 replaced as follows: bit 30 shows a pending single-step trap, and the other three read 0.
- R9: A control write loads the trap register in the same way, whether or not a trap is taken.
- R10: If control bit 26 is 1 at trap exit, the first `insn_retire` pulse after the exit raises a single-step request. That request is effective whenever the gate is 1, with no class enable needed. It causes a trap at the following edge and appears as trap register bit 30. If bit 26 is 0 at exit, no step trap occurs.
- R11: Trap register bits 14, 11 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control register write value |
| ctl_rd_data | output | 32 | Control register contents |
| trap_req | input | 32 | Trap request lines, one per trap register bit |
| trap_exit | input | 1 | Processor signals the end of the trap handler |
| insn_retire | input | 1 | One pulse per retired instruction |
| trap_entry | output | 1 | One-cycle trap entry pulse |
| trap_active | output | 1 | A trap is in progress |
| trap_reg | output | 32 | Captured trap register |

## Verification
The bench sweeps every request bit against every setting of the gate and the four class enables. A wrong class map or a missing gate term would therefore either trap on a masked line or miss an enabled one, and a design that lets the unused request bits through would show them in the trap register. Directed cases cover the following races:
- A control write in the entry cycle: a design that lets the write win leaves the gate open inside the handler.
- Software reopening the gate while requests are held: a design that checks only the gate would fire a second entry.
- An exit pulse with no trap active: a design that does not check for an active trap would set the gate.
- Single-step: a step trap that fires before the first retired instruction, or fires without the enable bit, shows up as an early or extra entry pulse.

// File: rtl/trap_cap_pkg.sv
package trap_cap_pkg;
  localparam int REG_W       = 32;
  localparam int NUM_CLASS   = 4;
  localparam int GATE_BIT    = 31;
  localparam int CLS_EN_LSB  = 27;
  localparam int STEP_EN_BIT = 26;
  localparam int STEP_REQ    = 30;
  localparam int CTL_LO      = STEP_EN_BIT;

  typedef enum logic [2:0] {
    CLS_SYNC  = 3'd0,
    CLS_DTYPE = 3'd1,
    CLS_OVF   = 3'd2,
    CLS_ASYNC = 3'd3,
    CLS_NONE  = 3'd4
  } trap_class_e;

  typedef enum logic [1:0] {
    STEP_OFF   = 2'd0,
    STEP_ARMED = 2'd1,
    STEP_PEND  = 2'd2
  } step_state_e;

  function automatic trap_class_e class_of(input int b);
    if (b >= 1 && b <= 10)               return CLS_ASYNC;
    if (b == 12)                         return CLS_OVF;
    if (b == 13)                         return CLS_DTYPE;
    if ((b >= 15 && b <= 29) || b == 31) return CLS_SYNC;
    return CLS_NONE;
  endfunction

  function automatic logic [REG_W-1:0] keep_mask();
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (class_of(i) != CLS_NONE);
    return m;
  endfunction

  function automatic logic [REG_W-1:0] ctl_mask();
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i >= CTL_LO);
    return m;
  endfunction

  localparam logic [REG_W-1:0] REQ_KEEP = keep_mask();
  localparam logic [REG_W-1:0] CTL_IMPL = ctl_mask();
endpackage

// File: rtl/trap_class_mask.sv
module trap_class_mask
  import trap_cap_pkg::*;
(
  input  logic                 gate,
  input  logic [NUM_CLASS-1:0] cls_en,
  input  logic [REG_W-1:0]     req,
  input  logic                 step_pend,
  output logic [REG_W-1:0]     raw_vec,
  output logic                 any_eff
);
  logic [REG_W-1:0] en_vec;
  logic [REG_W-1:0] eff_vec;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    localparam trap_class_e CLS = class_of(i);
    if (i == STEP_REQ) begin : g_step
      assign en_vec[i] = 1'b1;
    end else if (CLS == CLS_NONE) begin : g_none
      assign en_vec[i] = 1'b0;
    end else begin : g_cls
      assign en_vec[i] = cls_en[CLS[1:0]];
    end
  end

  always_comb begin
    raw_vec = req & REQ_KEEP;
    raw_vec[STEP_REQ] = step_pend;
    eff_vec = gate ? (raw_vec & en_vec) : '0;
    any_eff = |eff_vec;
  end
endmodule

// File: rtl/trap_ctl_reg.sv
module trap_ctl_reg
  import trap_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             entry_fire,
  input  logic             exit_fire,
  output logic [REG_W-1:0] ctl_q
);
  logic [REG_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en)      ctl_d = wr_data & CTL_IMPL;
    if (exit_fire)  ctl_d[GATE_BIT] = 1'b1;
    if (entry_fire) ctl_d[GATE_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_eff,
  input  logic trap_exit,
  input  logic insn_retire,
  input  logic step_en,
  output logic entry_fire,
  output logic exit_fire,
  output logic entry_q,
  output logic active_q,
  output logic step_pend
);
  step_state_e step_q;

  assign entry_fire = !active_q && any_eff;
  assign exit_fire  = active_q && trap_exit;
  assign step_pend  = (step_q == STEP_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      entry_q  <= 1'b0;
      step_q   <= STEP_OFF;
    end else begin
      entry_q <= entry_fire;
      if (entry_fire)     active_q <= 1'b1;
      else if (exit_fire) active_q <= 1'b0;
      if (entry_fire)                            step_q <= STEP_OFF;
      else if (exit_fire)                        step_q <= step_en ? STEP_ARMED : STEP_OFF;
      else if (step_q == STEP_ARMED && insn_retire) step_q <= STEP_PEND;
    end
  end
endmodule

// File: rtl/trap_capture.sv
module trap_capture
  import trap_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] raw_vec,
  output logic [REG_W-1:0] cap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cap_q <= '0;
    else if (load) cap_q <= raw_vec;
  end
endmodule

// File: rtl/trap_capture_unit.sv
module trap_capture_unit
  import trap_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wr_data,
  output logic [REG_W-1:0] ctl_rd_data,
  input  logic [REG_W-1:0] trap_req,
  input  logic             trap_exit,
  input  logic             insn_retire,
  output logic             trap_entry,
  output logic             trap_active,
  output logic [REG_W-1:0] trap_reg
);
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] raw_vec;
  logic             any_eff;
  logic             entry_fire;
  logic             exit_fire;
  logic             step_pend;

  trap_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctl_wr_en),
    .wr_data    (ctl_wr_data),
    .entry_fire (entry_fire),
    .exit_fire  (exit_fire),
    .ctl_q      (ctl_q)
  );

  trap_class_mask u_mask (
    .gate      (ctl_q[GATE_BIT]),
    .cls_en    (ctl_q[CLS_EN_LSB +: NUM_CLASS]),
    .req       (trap_req),
    .step_pend (step_pend),
    .raw_vec   (raw_vec),
    .any_eff   (any_eff)
  );

  trap_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_eff     (any_eff),
    .trap_exit   (trap_exit),
    .insn_retire (insn_retire),
    .step_en     (ctl_q[STEP_EN_BIT]),
    .entry_fire  (entry_fire),
    .exit_fire   (exit_fire),
    .entry_q     (trap_entry),
    .active_q    (trap_active),
    .step_pend   (step_pend)
  );

  trap_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (entry_fire | ctl_wr_en),
    .raw_vec (raw_vec),
    .cap_q   (trap_reg)
  );

  assign ctl_rd_data = ctl_q;
endmodule

// File: rtl/trap_capture_unit_checker.sv
module trap_capture_unit_checker
  import trap_cap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr_en,
  input logic [REG_W-1:0] ctl_wr_data,
  input logic [REG_W-1:0] ctl_rd_data,
  input logic [REG_W-1:0] trap_req,
  input logic             trap_exit,
  input logic             insn_retire,
  input logic             trap_entry,
  input logic             trap_active,
  input logic [REG_W-1:0] trap_reg
);
  localparam logic [REG_W-1:0] NO_STEP = ~(REG_W'(1) << STEP_REQ);

  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data & ~CTL_IMPL) == '0);
  assert_entry_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_entry |=> !trap_entry);
  assert_entry_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_entry |-> trap_active);
  assert_no_reentry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_active |=> !trap_entry);
  assert_gate_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_entry |-> !ctl_rd_data[GATE_BIT]);
  assert_exit_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_active && trap_exit) |=> (!trap_active && ctl_rd_data[GATE_BIT]));
  assert_idle_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_active && trap_exit && !ctl_wr_en) |=>
      (trap_entry || ctl_rd_data[GATE_BIT] == $past(ctl_rd_data[GATE_BIT])));
  assert_load_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> (trap_reg & NO_STEP) == ($past(trap_req) & REQ_KEEP));
  assert_spare_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_reg[0] && !trap_reg[11] && !trap_reg[14]);
endmodule

bind trap_capture_unit trap_capture_unit_checker u_chk (.*);

// File: tb/trap_capture_unit_tb.sv
`timescale 1ns/1ps
module trap_capture_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic [31:0] ctl_rd_data;
  logic [31:0] trap_req = '0;
  logic        trap_exit = 1'b0;
  logic        insn_retire = 1'b0;
  logic        trap_entry;
  logic        trap_active;
  logic [31:0] trap_reg;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  trap_capture_unit u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_fire(input logic [31:0] c, input int b);
    bit en;
    if (b >= 1 && b <= 10) en = c[30];
    else if (b == 12) en = c[29];
    else if (b == 13) en = c[28];
    else if ((b >= 15 && b <= 29) || b == 31) en = c[27];
    else en = 1'b0;
    return c[31] && en;
  endfunction

  function automatic logic [31:0] exp_cap(input logic [31:0] r);
    logic [31:0] m = r;
    m[0] = 0; m[11] = 0; m[14] = 0; m[30] = 0;
    return m;
  endfunction

  task automatic write_ctl(input logic [31:0] v);
    @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk); ctl_wr_en = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk); trap_exit = 1'b1;
    @(negedge clk); trap_exit = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", ctl_rd_data, 0);
    chk("R1 trap_reg", trap_reg, 0);
    chk("R1 active", {31'd0, trap_active}, 0);
    chk("R1 entry", {31'd0, trap_entry}, 0);

    // R2 unimplemented bits read zero
    write_ctl(32'hFFFF_FFFF);
    chk("R2 ctl mask", ctl_rd_data, 32'hFC00_0000);
    write_ctl(32'h0000_0000);

    // R11 / R9 snapshot of all-ones requests without a trap
    trap_req = 32'hFFFF_FFFF;
    write_ctl(32'h0000_0000);
    chk("R9 R11 snapshot", trap_reg, 32'hBFFF_B7FE);
    trap_req = '0;

    // R3 R4 R6 R7 R8 sweep: gate x class enables x request bit
    for (int g = 0; g < 2; g++) begin
      for (int en = 0; en < 16; en++) begin
        for (int b = 0; b < 32; b++) begin
          logic [31:0] c;
          bit f;
          c = {g[0], en[3:0], 27'd0};
          f = exp_fire(c, b);
          @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = c; trap_req = '0;
          @(negedge clk); ctl_wr_en = 1'b0; trap_req = 32'd1 << b;
          @(negedge clk);
          chk($sformatf("R3 R4 entry g=%0d en=%0h b=%0d", g, en, b), {31'd0, trap_entry}, {31'd0, f});
          chk($sformatf("R8 cap b=%0d", b), trap_reg, f ? exp_cap(32'd1 << b) : 32'd0);
          trap_req = '0;
          if (f) begin
            chk($sformatf("R6 gate b=%0d", b), {31'd0, ctl_rd_data[31]}, 0);
            trap_exit = 1'b1;
            @(negedge clk); trap_exit = 1'b0;
            chk($sformatf("R7 restore b=%0d", b), {30'd0, trap_active, ctl_rd_data[31]}, 32'd1);
          end
        end
      end
    end

    // R6 write in the entry cycle: gate cleared, other bits stored
    write_ctl(32'hC000_0000);
    @(negedge clk); trap_req = 32'h8; ctl_wr_en = 1'b1; ctl_wr_data = 32'hC800_0000;
    @(negedge clk); ctl_wr_en = 1'b0; trap_req = '0;
    chk("R6 entry beats write", ctl_rd_data, 32'h4800_0000);
    chk("R4 entry", {31'd0, trap_entry}, 1);
    @(negedge clk);
    chk("R4 single pulse", {31'd0, trap_entry}, 0);

    // R5 reopen gate in handler with request held
    trap_req = 32'h8;
    write_ctl(32'hC000_0000);
    @(negedge clk);
    chk("R5 no reentry", {31'd0, trap_entry}, 0);
    chk("R5 active", {31'd0, trap_active}, 1);
    pulse_exit();
    chk("R7 exit no entry yet", {31'd0, trap_entry}, 0);
    @(negedge clk);
    chk("R4 reentry after exit", {31'd0, trap_entry}, 1);
    trap_req = '0;
    pulse_exit();

    // R7 exit while idle ignored
    write_ctl(32'h0000_0000);
    pulse_exit();
    @(negedge clk);
    chk("R7 idle exit", ctl_rd_data, 32'h0);

    // R10 single-step enabled
    write_ctl(32'hC400_0000);
    @(negedge clk); trap_req = 32'h8;
    @(negedge clk); trap_req = '0;
    chk("R10 first entry", {31'd0, trap_entry}, 1);
    pulse_exit();
    @(negedge clk);
    chk("R10 no step before retire", {31'd0, trap_entry}, 0);
    insn_retire = 1'b1;
    @(negedge clk); insn_retire = 1'b0;
    chk("R10 not yet", {31'd0, trap_entry}, 0);
    @(negedge clk);
    chk("R10 step entry", {31'd0, trap_entry}, 1);
    chk("R10 step capture", trap_reg, 32'h4000_0000);
    write_ctl(32'h0000_0000);
    pulse_exit();

    // R10 single-step disabled
    write_ctl(32'hC000_0000);
    @(negedge clk); trap_req = 32'h8;
    @(negedge clk); trap_req = '0;
    pulse_exit();
    @(negedge clk); insn_retire = 1'b1;
    @(negedge clk); insn_retire = 1'b0;
    @(negedge clk);
    chk("R10 no step when off", {30'd0, trap_active, trap_entry}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule